// File: doc/BRIEF.md
# Texel Fetch and Filter Unit

This unit turns one texture sample request into a filtered RGBA8888 colour. A request carries a signed integer texel position (u, v), a fractional position inside the texel cell, the texture's width and height as base-2 logarithms, a mip level, a wrap mode for each axis, a texel format and the word address of the chosen level's image. The unit folds each coordinate back into the level's extent. It forms the 32-bit word address of each texel it needs, reads that word through a memory port with a fixed one-cycle latency, and widens the texel to eight bits per channel. The two indexed formats go through a small colour table that is loaded through its own write port.

In nearest mode one texel is read and returned unchanged after widening. In bilinear mode the 2x2 neighbourhood is read one texel at a time. Each texel is weighted by the product of its 4-bit fractional distances, and the four weighted values are summed and rounded to eight bits per channel. Requests enter through a valid/ready port and results leave through a valid/ready port. The unit works on one request at a time, so a new request is taken only after the previous result has been accepted.

Top module: `tex_sampler_unit`

## Requirements
- R1: `in_ready` is high only while no request is in flight; a request is taken on a clock edge where `in_valid` and `in_ready` are both high. Once `out_valid` rises, it and `out_rgba` stay unchanged until a clock edge with `out_ready` high, and `in_ready` returns high on the following cycle.
- R2: The texel index is y*W + x in row-major order, with W the level width. Texels pack little-endian into 32-bit words at 32, 16, 8 or 4 bits each, so the word address is base + (index >> 0, 1, 2 or 3), wrapping modulo 2^32.
- R3: Wrap code 0 (repeat) keeps the low log2(size) bits of the coordinate, so negative coordinates wrap too.
- R4: Wrap code 1 (clamp) maps negative coordinates to 0 and coordinates at or above the size to size-1.
- R5: Wrap code 2 (mirror) reflects the coordinate with period 2*size: a coordinate c maps to c mod 2size when that is below size, and to 2size-1-(c mod 2size) otherwise.
- R6: Format code 0 holds 32 bits per texel with R in bits 31:24, G in 23:16, B in 15:8 and A in 7:0, and is returned unchanged. `out_rgba` always uses this layout.
- R7: Format code 1 holds 16 bits per texel as R 15:12, G 11:8, B 7:4, A 3:0. Each 4-bit channel n widens to {n, n}. The even texel of a word is in bits 15:0.
- R8: Format code 2 holds 16 bits per texel as R 15:11, G 10:5, B 4:0. A 5-bit value v widens to {v, v[4:2]}, a 6-bit value g widens to {g, g[5:4]}, and alpha is 0xFF.
- R9: Format code 3 holds 8-bit table indices. Texel k of a word uses bits 8k+7:8k, and the output is the table entry at that index.
- R10: Format code 4 holds 4-bit table indices. Texel k of a word uses bits 4k+3:4k, so an even texel sits in the low nibble of its byte and an odd texel in the high nibble.
- R11: In nearest mode (`in_bilinear` low) exactly one memory read is made, at the texel (u, v).
- R12: In bilinear mode exactly four reads are made, at (u,v), (u+1,v), (u,v+1) and (u+1,v+1) after wrapping, in that order. With weights (16-fu)(16-fv), fu(16-fv), (16-fu)fv and fu*fv, each channel is (sum of weight*channel + 128) >> 8.
- R13: At mip level L, each axis uses log2 size max(log2size - L, 0), so a level never shrinks below one texel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_u | input | COORD_W | Signed texel column |
| in_v | input | COORD_W | Signed texel row |
| in_fu | input | FRAC_W | Horizontal fraction for bilinear weights |
| in_fv | input | FRAC_W | Vertical fraction for bilinear weights |
| in_log2w | input | LOG2_W | Base width as log2, at most LOG2_MAX |
| in_log2h | input | LOG2_W | Base height as log2, at most LOG2_MAX |
| in_level | input | LVL_W | Mip level |
| in_wrap_u | input | 2 | Horizontal wrap code |
| in_wrap_v | input | 2 | Vertical wrap code |
| in_fmt | input | 3 | Texel format code |
| in_bilinear | input | 1 | 1 selects bilinear, 0 nearest |
| in_base | input | ADDR_W | Word address of the level image |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | 32 | Read word, valid one cycle after the strobe |
| pal_we | input | 1 | Colour table write enable |
| pal_waddr | input | PAL_AW | Colour table write index |
| pal_wdata | input | 32 | Colour table entry in output layout |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_rgba | output | 32 | Filtered colour |

## Verification
The bench builds the unit with its default parameters: 16-bit coordinates, sizes up to 2^10, 4-bit fractions, 32-bit addresses and a 256-entry colour table. Random log2 sizes from 0 to 6, combined with coordinates from -100 to 180, push all three wrap modes past both edges of each axis, and the one-texel case is common. Levels up to 3, plus a directed level above the size's log2, reach the one-texel minimum. A 32-bit base near the top of the address space shows the address wrapping.

// File: rtl/tex_pkg.sv
package tex_pkg;

  localparam int TEXEL_W = 32;

  typedef enum logic [2:0] {
    FMT_RGBA8888 = 3'd0,
    FMT_RGBA4444 = 3'd1,
    FMT_RGB565   = 3'd2,
    FMT_PAL8     = 3'd3,
    FMT_PAL4     = 3'd4
  } tex_fmt_e;

  typedef enum logic [1:0] {
    WRAP_REPEAT = 2'd0,
    WRAP_CLAMP  = 2'd1,
    WRAP_MIRROR = 2'd2
  } tex_wrap_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } tex_state_e;

  // Channel widening: the high bits are repeated into the freed low bits.
  function automatic logic [7:0] widen4(input logic [3:0] n);
    return {n, n};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] n);
    return {n, n[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] n);
    return {n, n[5:4]};
  endfunction

endpackage

// File: rtl/tex_wrap_axis.sv
module tex_wrap_axis
  import tex_pkg::*;
#(
  parameter int COORD_W  = 16,
  parameter int LOG2_MAX = 10,
  parameter int LOG2_W   = 4
) (
  input  logic signed [COORD_W-1:0] coord_i,
  input  logic [LOG2_W-1:0]         lg_i,
  input  logic [1:0]                mode_i,
  output logic [LOG2_MAX-1:0]       pos_o
);

  logic [COORD_W-1:0]        mask;
  logic [COORD_W-1:0]        res;
  logic signed [COORD_W-1:0] above;

  always_comb begin
    mask  = ~({COORD_W{1'b1}} << lg_i);
    above = coord_i >>> lg_i;
    res   = coord_i & mask;
    case (mode_i)
      WRAP_CLAMP: begin
        if (coord_i[COORD_W-1]) res = '0;
        else if (above != '0)   res = mask;
      end
      WRAP_MIRROR: begin
        // odd period: reflect by inverting the in-range bits
        if (coord_i[lg_i]) res = ~coord_i & mask;
      end
      default: ;
    endcase
    pos_o = res[LOG2_MAX-1:0];
  end

endmodule

// File: rtl/tex_addr_gen.sv
module tex_addr_gen
  import tex_pkg::*;
#(
  parameter int LOG2_MAX = 10,
  parameter int LOG2_W   = 4,
  parameter int ADDR_W   = 32
) (
  input  logic [LOG2_MAX-1:0] x_i,
  input  logic [LOG2_MAX-1:0] y_i,
  input  logic [LOG2_W-1:0]   lw_i,
  input  logic [2:0]          fmt_i,
  input  logic [ADDR_W-1:0]   base_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [2:0]          sub_o
);

  localparam int IDX_W = 2 * LOG2_MAX;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] off;
  logic [1:0]       sh;
  logic [2:0]       sub_mask;

  always_comb begin
    idx = (IDX_W'(y_i) << lw_i) | IDX_W'(x_i);
    case (fmt_i)
      FMT_RGBA8888: begin sh = 2'd0; sub_mask = 3'b000; end
      FMT_RGBA4444,
      FMT_RGB565:   begin sh = 2'd1; sub_mask = 3'b001; end
      FMT_PAL8:     begin sh = 2'd2; sub_mask = 3'b011; end
      default:      begin sh = 2'd3; sub_mask = 3'b111; end
    endcase
    off    = idx >> sh;
    addr_o = base_i + ADDR_W'(off);
    sub_o  = idx[2:0] & sub_mask;
  end

endmodule

// File: rtl/tex_fmt_decode.sv
module tex_fmt_decode
  import tex_pkg::*;
#(
  parameter int PAL_AW = 8
) (
  input  logic [2:0]         fmt_i,
  input  logic [31:0]        word_i,
  input  logic [2:0]         sub_i,
  output logic [PAL_AW-1:0]  pal_raddr_o,
  input  logic [31:0]        pal_rdata_i,
  output logic [31:0]        rgba_o
);

  logic [15:0] half;
  logic [7:0]  byt;
  logic [3:0]  nib;

  always_comb begin
    half        = sub_i[0] ? word_i[31:16] : word_i[15:0];
    byt         = word_i[{sub_i[1:0], 3'b000} +: 8];
    nib         = word_i[{sub_i, 2'b00} +: 4];
    pal_raddr_o = (fmt_i == FMT_PAL4) ? PAL_AW'(nib) : PAL_AW'(byt);
    case (fmt_i)
      FMT_RGBA8888: rgba_o = word_i;
      FMT_RGBA4444: rgba_o = {widen4(half[15:12]), widen4(half[11:8]),
                              widen4(half[7:4]), widen4(half[3:0])};
      FMT_RGB565:   rgba_o = {widen5(half[15:11]), widen6(half[10:5]),
                              widen5(half[4:0]), 8'hFF};
      FMT_PAL8,
      FMT_PAL4:     rgba_o = pal_rdata_i;
      default:      rgba_o = '0;
    endcase
  end

endmodule

// File: rtl/tex_palette_ram.sv
module tex_palette_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/tex_blend_acc.sv
module tex_blend_acc #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [2*FRAC_W:0] weight_i,
  input  logic [31:0]       rgba_i,
  output logic [31:0]       rgba_o
);

  localparam int WGT_W = 2 * FRAC_W + 1;
  localparam int ACC_W = 8 + WGT_W;
  localparam int SHIFT = 2 * FRAC_W;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);

  for (genvar c = 0; c < 4; c++) begin : g_chan
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] rnd;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (clear_i) acc <= '0;
      else if (en_i)    acc <= acc + ACC_W'(weight_i) * ACC_W'(rgba_i[8*c +: 8]);
    end

    assign rnd = acc + HALF;
    assign rgba_o[8*c +: 8] = rnd[SHIFT +: 8];
  end

endmodule

// File: rtl/tex_sampler_unit.sv
module tex_sampler_unit
  import tex_pkg::*;
#(
  parameter int COORD_W  = 16,
  parameter int LOG2_MAX = 10,
  parameter int LVL_W    = 4,
  parameter int FRAC_W   = 4,
  parameter int ADDR_W   = 32,
  parameter int PAL_AW   = 8,
  parameter int LOG2_W   = $clog2(LOG2_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [COORD_W-1:0]  in_u,
  input  logic [COORD_W-1:0]  in_v,
  input  logic [FRAC_W-1:0]   in_fu,
  input  logic [FRAC_W-1:0]   in_fv,
  input  logic [LOG2_W-1:0]   in_log2w,
  input  logic [LOG2_W-1:0]   in_log2h,
  input  logic [LVL_W-1:0]    in_level,
  input  logic [1:0]          in_wrap_u,
  input  logic [1:0]          in_wrap_v,
  input  logic [2:0]          in_fmt,
  input  logic                in_bilinear,
  input  logic [ADDR_W-1:0]   in_base,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [31:0]         mem_rdata,
  input  logic                pal_we,
  input  logic [PAL_AW-1:0]   pal_waddr,
  input  logic [31:0]         pal_wdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_rgba
);

  localparam int CW = ((LOG2_W > LVL_W) ? LOG2_W : LVL_W) + 1;
  localparam int PW = 2 * FRAC_W + 2;
  localparam logic [FRAC_W:0]   ONE_F   = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [2*FRAC_W:0] ONE_SQ  = {1'b1, {(2*FRAC_W){1'b0}}};

  tex_state_e state_q;

  logic signed [COORD_W-1:0] u_q, v_q;
  logic [FRAC_W-1:0]         fu_q, fv_q;
  logic [LOG2_W-1:0]         lw_q, lh_q;
  logic [1:0]                wu_q, wv_q;
  logic [2:0]                fmt_q;
  logic                      bil_q;
  logic [ADDR_W-1:0]         base_q;
  logic [1:0]                tap_q;

  logic                      accept;
  logic                      last_tap;

  // ---- level size reduction ----
  logic [CW-1:0]     lw_ext, lh_ext, lvl_ext, lw_dif, lh_dif;
  logic [LOG2_W-1:0] lw_e, lh_e;

  always_comb begin
    lw_ext  = CW'(in_log2w);
    lh_ext  = CW'(in_log2h);
    lvl_ext = CW'(in_level);
    lw_dif  = lw_ext - lvl_ext;
    lh_dif  = lh_ext - lvl_ext;
    lw_e    = (lw_ext > lvl_ext) ? LOG2_W'(lw_dif) : '0;
    lh_e    = (lh_ext > lvl_ext) ? LOG2_W'(lh_dif) : '0;
  end

  assign accept   = (state_q == ST_IDLE) && in_valid;
  assign last_tap = !bil_q || (tap_q == 2'd3);

  // ---- request capture and tap sequencing ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      u_q     <= '0;
      v_q     <= '0;
      fu_q    <= '0;
      fv_q    <= '0;
      lw_q    <= '0;
      lh_q    <= '0;
      wu_q    <= '0;
      wv_q    <= '0;
      fmt_q   <= '0;
      bil_q   <= 1'b0;
      base_q  <= '0;
      tap_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            u_q     <= in_u;
            v_q     <= in_v;
            fu_q    <= in_fu;
            fv_q    <= in_fv;
            lw_q    <= lw_e;
            lh_q    <= lh_e;
            wu_q    <= in_wrap_u;
            wv_q    <= in_wrap_v;
            fmt_q   <= in_fmt;
            bil_q   <= in_bilinear;
            base_q  <= in_base;
            tap_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (last_tap) begin
            state_q <= ST_DONE;
          end else begin
            tap_q   <= tap_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: begin
          if (out_ready) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign mem_rd_en = (state_q == ST_ISSUE);
  assign out_valid = (state_q == ST_DONE);

  // ---- per-axis wrapping of the current tap ----
  logic signed [COORD_W-1:0] ax_coord [2];
  logic [LOG2_W-1:0]         ax_lg    [2];
  logic [1:0]                ax_mode  [2];
  logic [LOG2_MAX-1:0]       ax_pos   [2];

  always_comb begin
    ax_coord[0] = u_q + {{(COORD_W-1){1'b0}}, tap_q[0]};
    ax_coord[1] = v_q + {{(COORD_W-1){1'b0}}, tap_q[1]};
    ax_lg[0]    = lw_q;
    ax_lg[1]    = lh_q;
    ax_mode[0]  = wu_q;
    ax_mode[1]  = wv_q;
  end

  for (genvar a = 0; a < 2; a++) begin : g_axis
    tex_wrap_axis #(
      .COORD_W (COORD_W),
      .LOG2_MAX(LOG2_MAX),
      .LOG2_W  (LOG2_W)
    ) u_wrap (
      .coord_i(ax_coord[a]),
      .lg_i   (ax_lg[a]),
      .mode_i (ax_mode[a]),
      .pos_o  (ax_pos[a])
    );
  end

  // ---- address and sub-word position ----
  logic [2:0] sub_idx;

  tex_addr_gen #(
    .LOG2_MAX(LOG2_MAX),
    .LOG2_W  (LOG2_W),
    .ADDR_W  (ADDR_W)
  ) u_addr (
    .x_i   (ax_pos[0]),
    .y_i   (ax_pos[1]),
    .lw_i  (lw_q),
    .fmt_i (fmt_q),
    .base_i(base_q),
    .addr_o(mem_addr),
    .sub_o (sub_idx)
  );

  // ---- texel expansion ----
  logic [PAL_AW-1:0] pal_raddr;
  logic [31:0]       pal_rdata;
  logic [31:0]       texel_rgba;

  tex_palette_ram #(
    .AW(PAL_AW),
    .DW(TEXEL_W)
  ) u_pal (
    .clk    (clk),
    .we_i   (pal_we),
    .waddr_i(pal_waddr),
    .wdata_i(pal_wdata),
    .raddr_i(pal_raddr),
    .rdata_o(pal_rdata)
  );

  tex_fmt_decode #(
    .PAL_AW(PAL_AW)
  ) u_dec (
    .fmt_i      (fmt_q),
    .word_i     (mem_rdata),
    .sub_i      (sub_idx),
    .pal_raddr_o(pal_raddr),
    .pal_rdata_i(pal_rdata),
    .rgba_o     (texel_rgba)
  );

  // ---- tap weight ----
  logic [FRAC_W:0]   u_fac, v_fac;
  logic [PW-1:0]     w_prod;
  logic [2*FRAC_W:0] weight;

  always_comb begin
    u_fac  = tap_q[0] ? {1'b0, fu_q} : ONE_F - {1'b0, fu_q};
    v_fac  = tap_q[1] ? {1'b0, fv_q} : ONE_F - {1'b0, fv_q};
    w_prod = PW'(u_fac) * PW'(v_fac);
    weight = bil_q ? w_prod[2*FRAC_W:0] : ONE_SQ;
  end

  tex_blend_acc #(
    .FRAC_W(FRAC_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .en_i    (state_q == ST_WAIT),
    .weight_i(weight),
    .rgba_i  (texel_rgba),
    .rgba_o  (out_rgba)
  );

endmodule

// File: rtl/tex_sampler_unit_chk.sv
module tex_sampler_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_bilinear,
  input logic        mem_rd_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_rgba
);

  logic [2:0] rd_cnt;
  logic       bil_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      bil_seen <= 1'b0;
    end else if (in_valid && in_ready) begin
      rd_cnt   <= '0;
      bil_seen <= in_bilinear;
    end else if (mem_rd_en) begin
      rd_cnt   <= rd_cnt + 3'd1;
    end
  end

  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  p_out_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_rgba));

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid && !mem_rd_en);

  p_read_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_tap_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> rd_cnt == (bil_seen ? 3'd4 : 3'd1));

endmodule

bind tex_sampler_unit tex_sampler_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_bilinear(in_bilinear),
  .mem_rd_en  (mem_rd_en),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_rgba   (out_rgba)
);

// File: tb/tex_sampler_unit_tb_top.sv
`timescale 1ns/1ps
module tex_sampler_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_u = '0, in_v = '0;
  logic [3:0]  in_fu = '0, in_fv = '0;
  logic [3:0]  in_log2w = '0, in_log2h = '0;
  logic [3:0]  in_level = '0;
  logic [1:0]  in_wrap_u = '0, in_wrap_v = '0;
  logic [2:0]  in_fmt = '0;
  logic        in_bilinear = 1'b0;
  logic [31:0] in_base = '0;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_waddr = '0;
  logic [31:0] pal_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_rgba;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  bit done = 0;
  logic [31:0] pal_ref [256];

  always #2 clk = ~clk;

  tex_sampler_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_u(in_u), .in_v(in_v), .in_fu(in_fu), .in_fv(in_fv),
    .in_log2w(in_log2w), .in_log2h(in_log2h), .in_level(in_level),
    .in_wrap_u(in_wrap_u), .in_wrap_v(in_wrap_v), .in_fmt(in_fmt),
    .in_bilinear(in_bilinear), .in_base(in_base),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgba(out_rgba)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    logic [31:0] x;
    x = a * 32'h9E37_79B1;
    return x ^ (x >> 15) ^ 32'h3C6E_F372;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memf(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  function automatic int wrap_ref(input int c, input int lg, input int mode);
    int size, m;
    size = 1 << lg;
    if (mode == 1) return (c < 0) ? 0 : ((c >= size) ? size - 1 : c);
    if (mode == 2) begin
      m = ((c % (2 * size)) + 2 * size) % (2 * size);
      return (m < size) ? m : 2 * size - 1 - m;
    end
    return ((c % size) + size) % size;
  endfunction

  function automatic logic [7:0] e4(input int n); return 8'(n * 17); endfunction
  function automatic logic [7:0] e5(input int n); return 8'((n << 3) | (n >> 2)); endfunction
  function automatic logic [7:0] e6(input int n); return 8'((n << 2) | (n >> 4)); endfunction

  function automatic logic [31:0] texel_ref(input int x, input int y, input int lw,
                                            input int fmt, input logic [31:0] base);
    int idx, sh;
    logic [31:0] w, h;
    idx = (y << lw) + x;
    sh  = (fmt == 0) ? 0 : (fmt <= 2) ? 1 : (fmt == 3) ? 2 : 3;
    w   = memf(base + 32'(idx >> sh));
    h   = (idx % 2 == 1) ? (w >> 16) : (w & 32'hFFFF);
    case (fmt)
      0: return w;
      1: return {e4(int'(h[15:12])), e4(int'(h[11:8])), e4(int'(h[7:4])), e4(int'(h[3:0]))};
      2: return {e5(int'(h[15:11])), e6(int'(h[10:5])), e5(int'(h[4:0])), 8'hFF};
      3: return pal_ref[(w >> (8 * (idx % 4))) & 32'hFF];
      default: return pal_ref[(w >> (4 * (idx % 8))) & 32'hF];
    endcase
  endfunction

  function automatic logic [31:0] color_ref(input int u, input int v, input int fu, input int fv,
                                            input int lw, input int lh, input int lvl,
                                            input int wu, input int wv, input int fmt,
                                            input bit bil, input logic [31:0] base);
    int ew, eh, x, y, wt;
    int acc [4];
    logic [31:0] t, r;
    ew = (lw > lvl) ? lw - lvl : 0;
    eh = (lh > lvl) ? lh - lvl : 0;
    if (!bil) return texel_ref(wrap_ref(u, ew, wu), wrap_ref(v, eh, wv), ew, fmt, base);
    for (int c = 0; c < 4; c++) acc[c] = 0;
    for (int k = 0; k < 4; k++) begin
      x  = wrap_ref(u + (k & 1), ew, wu);
      y  = wrap_ref(v + (k >> 1), eh, wv);
      wt = (((k & 1) != 0) ? fu : 16 - fu) * (((k >> 1) != 0) ? fv : 16 - fv);
      t  = texel_ref(x, y, ew, fmt, base);
      for (int c = 0; c < 4; c++) acc[c] += wt * int'((t >> (8 * c)) & 32'hFF);
    end
    for (int c = 0; c < 4; c++) r[8*c +: 8] = 8'((acc[c] + 128) >> 8);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input string tag, input int u, input int v, input int fu, input int fv,
                         input int lw, input int lh, input int lvl, input int wu, input int wv,
                         input int fmt, input bit bil, input logic [31:0] base, input int hold);
    logic [31:0] exp, first;
    bit ok;
    exp = color_ref(u, v, fu, fv, lw, lh, lvl, wu, wv, fmt, bil, base);
    @(negedge clk);
    in_u = 16'(u); in_v = 16'(v); in_fu = 4'(fu); in_fv = 4'(fv);
    in_log2w = 4'(lw); in_log2h = 4'(lh); in_level = 4'(lvl);
    in_wrap_u = 2'(wu); in_wrap_v = 2'(wv); in_fmt = 3'(fmt);
    in_bilinear = bil; in_base = base; in_valid = 1'b1;
    rd_cnt = 0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    check(tag, out_rgba, exp);
    if (bil) check("R12 read count", 32'(rd_cnt), 32'd4);
    else     check("R11 read count", 32'(rd_cnt), 32'd1);
    if (hold > 0) begin
      first = out_rgba;
      ok = 1;
      repeat (hold) begin
        @(negedge clk);
        if (!out_valid || out_rgba !== first) ok = 0;
      end
      check("R1 hold under back-pressure", 32'(ok), 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R1 idle after accept", {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    string ftag [5];
    ftag[0] = "R6"; ftag[1] = "R7"; ftag[2] = "R8"; ftag[3] = "R9"; ftag[4] = "R10";
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {29'd0, in_ready, out_valid, mem_rd_en}, 32'd4);

    for (int i = 0; i < 256; i++) begin
      pal_ref[i] = (32'(i) * 32'h0123_4567) ^ 32'hA5A5_0F0F;
      pal_we = 1'b1; pal_waddr = 8'(i); pal_wdata = pal_ref[i];
      @(negedge clk);
    end
    pal_we = 1'b0;

    run_req("R6",   5,   3, 0, 0, 3, 3, 0, 0, 0, 0, 0, 32'h0000_1000, 0);
    run_req("R3",  -1,  -9, 0, 0, 3, 2, 0, 0, 0, 0, 0, 32'h0000_2000, 0);
    run_req("R4",  -5, 300, 0, 0, 4, 4, 0, 1, 1, 0, 0, 32'h0000_3000, 0);
    run_req("R5",   9,  -1, 0, 0, 3, 3, 0, 2, 2, 1, 0, 32'h0000_4000, 0);
    run_req("R13",  7,   5, 0, 0, 3, 2, 5, 0, 0, 0, 0, 32'h0000_5000, 0);
    run_req("R13",  6,   3, 0, 0, 4, 4, 2, 1, 1, 2, 0, 32'h0000_5800, 0);
    run_req("R8",   3,   1, 0, 0, 2, 2, 0, 0, 0, 2, 0, 32'h0000_6000, 0);
    run_req("R7",   2,   1, 0, 0, 2, 2, 0, 0, 0, 1, 0, 32'h0000_6400, 0);
    run_req("R9",   5,   0, 0, 0, 3, 3, 0, 0, 0, 3, 0, 32'h0000_6800, 0);
    run_req("R10",  0,   0, 0, 0, 3, 3, 0, 0, 0, 4, 0, 32'h0000_6C00, 0);
    run_req("R10",  1,   0, 0, 0, 3, 3, 0, 0, 0, 4, 0, 32'h0000_6C00, 0);
    run_req("R2",  13,   9, 0, 0, 5, 5, 0, 0, 0, 4, 0, 32'hFFFF_FFF0, 0);
    run_req("R12",  7,   7, 8, 8, 3, 3, 0, 0, 0, 0, 1, 32'h0000_7000, 3);
    run_req("R12",  7,   7,15,15, 3, 3, 0, 1, 1, 0, 1, 32'h0000_7400, 0);
    run_req("R5",  -3,  10, 5,11, 3, 3, 0, 2, 2, 1, 1, 32'h0000_7800, 0);

    for (int i = 0; i < 300; i++) begin
      int fmt, hold;
      fmt  = int'($urandom_range(0, 4));
      hold = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 4)) : 0;
      run_req(ftag[fmt],
              int'($urandom_range(0, 280)) - 100, int'($urandom_range(0, 280)) - 100,
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
              int'($urandom_range(0, 3)),
              int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
              fmt, 1'($urandom_range(0, 1)), $urandom(), hold);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule